// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write an array of word-wide registers held elsewhere on the chip. The master owns the serial clock. It frames each transaction by pulling the active-low chip select low and then shifts in three kinds of word, each one word wide and most significant bit first: a command word, an address word, and one or more data words. The block sits inside the core clock domain. Its four SPI pins pass through two-flop synchronisers, and it finds clock edges by oversampling, so the core clock must run well above the serial clock. Each phase of the serial clock, high and low, must last at least four core clock cycles.

On the register side the block drives a simple synchronous bus: an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data is returned one core cycle after the read strobe. If the master keeps chip select low after a data word, the transfer continues as a burst. Each further word moves one register on, and the address wraps at the top of the space. Writes take effect only for complete words. For reads, the next register is fetched as soon as the previous word ends, so that its first bit is ready on the next falling edge.

Top module: `spi_reg_port`

## Requirements
- R1: While rst_ni is low, spi_miso_o, spi_miso_oe_o, reg_we_o and reg_re_o are all 0.
- R2: Whenever chip select is high (after synchronisation), spi_miso_oe_o is 0 and spi_miso_o is 0.
- R3: A first word of 0x0002, followed by an address word and a data word, gives exactly one reg_we_o pulse. During that pulse, reg_addr_o equals the address word and reg_wdata_o equals the data word. MOSI is sampled on rising serial clock edges, MSB first.
- R4: A first word of 0x0003, followed by an address word, gives a reg_re_o pulse carrying that address. The value returned on reg_rdata_i one cycle later appears on spi_miso_o during the next word, MSB first. It is updated on falling serial clock edges, so its MSB is valid at the first rising edge of that word.
- R5: In a write burst, the k-th data word (k from 0) is written to the start address plus k.
- R6: In a read burst, the k-th data word returns the register at the start address plus k. One read strobe is issued for each completed address or data word.
- R7: Address increments wrap from 0xFFFF to 0x0000 in both write and read bursts.
- R8: Any first word other than 0x0002 or 0x0003 causes no strobes, and spi_miso_o stays 0 until chip select rises.
- R9: A data word cut short by chip select rising produces no write strobe.
- R10: Chip select rising resets the bit framing, so the next transaction is decoded from its first bit whatever came before.
- R11: reg_we_o and reg_re_o are never high together, each pulse lasts one cycle, and neither is issued while spi_miso_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from the master |
| spi_cs_ni | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| spi_miso_oe_o | output | 1 | Output enable for MISO, high while selected |
| reg_addr_o | output | W | Register bus address |
| reg_wdata_o | output | W | Register bus write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | W | Read data, valid one cycle after reg_re_o |

## Verification
The bench builds the block with its default word width W of 16 and the default opcodes. With these values the real command encodings apply, and bursts can start at 0xFFFF or 0xFFFE, so both the write and the read wrap to 0x0000 are reached. The serial clock runs at one sixteenth of the core clock. That leaves several cycles between a word's last rising edge and the next falling edge, enough to see whether the read data is prefetched in time.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [2:0] {
    FR_CMD,
    FR_WADDR,
    FR_RADDR,
    FR_WR,
    FR_RD,
    FR_IGN
  } frame_st_e;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= RST_VAL[g];
        s2_q[g] <= RST_VAL[g];
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame
  import spi_reg_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] CMD_WR = W'(2),
  parameter logic [W-1:0] CMD_RD = W'(3)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_act_i,
  input  logic         rise_i,
  input  logic         mosi_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wdata_o,
  output logic         we_o,
  output logic         re_o
);
  localparam int CW = $clog2(W);

  frame_st_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] sh_q, addr_q, wdata_q, word;
  logic         we_q, re_q, last;

  assign word = {sh_q[W-2:0], mosi_i};
  assign last = (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FR_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      // step past a written register once its strobe is out
      if (we_q) addr_q <= addr_q + W'(1);
      if (!cs_act_i) begin
        st_q  <= FR_CMD;
        cnt_q <= '0;
      end else if (rise_i) begin
        sh_q  <= word;
        cnt_q <= last ? '0 : cnt_q + CW'(1);
        if (last) begin
          unique case (st_q)
            FR_CMD: begin
              if (word == CMD_WR)      st_q <= FR_WADDR;
              else if (word == CMD_RD) st_q <= FR_RADDR;
              else                     st_q <= FR_IGN;
            end
            FR_WADDR: begin
              addr_q <= word;
              st_q   <= FR_WR;
            end
            FR_RADDR: begin
              addr_q <= word;
              re_q   <= 1'b1;
              st_q   <= FR_RD;
            end
            FR_WR: begin
              wdata_q <= word;
              we_q    <= 1'b1;
            end
            FR_RD: begin
              // prefetch the next register for the following word
              addr_q <= addr_q + W'(1);
              re_q   <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign re_o    = re_q;
endmodule

// File: rtl/spi_reg_tx.sv
module spi_reg_tx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_act_i,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         miso_o
);
  logic [W-1:0] sh_q;
  logic         bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (!cs_act_i) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= data_i;
    end else if (fall_i) begin
      bit_q <= sh_q[W-1];
      sh_q  <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign miso_o = bit_q;
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int W = 16,
  parameter logic [W-1:0] CMD_WR = W'(2),
  parameter logic [W-1:0] CMD_RD = W'(3)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         spi_sclk_i,
  input  logic         spi_cs_ni,
  input  logic         spi_mosi_i,
  output logic         spi_miso_o,
  output logic         spi_miso_oe_o,
  output logic [W-1:0] reg_addr_o,
  output logic [W-1:0] reg_wdata_o,
  output logic         reg_we_o,
  output logic         reg_re_o,
  input  logic [W-1:0] reg_rdata_i
);
  logic [2:0] pins_s;
  logic sclk_s, cs_n_s, mosi_s, sclk_d, rise, fall, cs_act;
  logic load_q, oe_q, tx_bit;

  // bit order: mosi, cs_n, sclk; cs idles high
  spi_reg_sync #(.N(3), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_mosi_i, spi_cs_ni, spi_sclk_i}),
    .q_o   (pins_s)
  );
  assign {mosi_s, cs_n_s, sclk_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      load_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      load_q <= reg_re_o;
      oe_q   <= cs_act;
    end
  end

  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign cs_act = ~cs_n_s;

  spi_reg_frame #(.W(W), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)) i_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_act_i(cs_act),
    .rise_i  (rise),
    .mosi_i  (mosi_s),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .we_o    (reg_we_o),
    .re_o    (reg_re_o)
  );

  spi_reg_tx #(.W(W)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_act_i(cs_act),
    .fall_i  (fall),
    .load_i  (load_q),
    .data_i  (reg_rdata_i),
    .miso_o  (tx_bit)
  );

  assign spi_miso_oe_o = oe_q;
  assign spi_miso_o    = tx_bit & oe_q;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         spi_miso_o,
  input logic         spi_miso_oe_o,
  input logic         reg_we_o,
  input logic         reg_re_o,
  input logic [W-1:0] reg_addr_o
);
  // R2
  miso_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_miso_oe_o |-> !spi_miso_o);

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  // R11
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R11
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  // R11
  strobe_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> spi_miso_oe_o);

  // R5
  wr_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + W'(1)));
endmodule

bind spi_reg_port spi_reg_port_chk #(.W(W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .spi_miso_o   (spi_miso_o),
  .spi_miso_oe_o(spi_miso_oe_o),
  .reg_we_o     (reg_we_o),
  .reg_re_o     (reg_re_o),
  .reg_addr_o   (reg_addr_o)
);

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [15:0] RD_KEY = 16'hA5C3;
  localparam int NVEC = 8;
  // {command, start address, word count, first write data}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'h0002, 16'h0010, 16'd1, 16'h1234},
    {16'h0003, 16'h0020, 16'd1, 16'h0000},
    {16'h0002, 16'h0100, 16'd3, 16'hBEEF},
    {16'h0003, 16'h7FFE, 16'd3, 16'h0000},
    {16'h0002, 16'hFFFF, 16'd2, 16'h5555},
    {16'h0003, 16'hFFFE, 16'd3, 16'h0000},
    {16'h0001, 16'h0040, 16'd2, 16'hFFFF},
    {16'h8002, 16'h0050, 16'd1, 16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, we, re;
  logic [W-1:0] addr, wdata, rdata;

  int errors = 0, checks = 0;
  int wr_total = 0, rd_total = 0;
  logic [15:0] log_addr [32];
  logic [15:0] log_data [32];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_reg_port #(.W(W)) i_spi_reg_port (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sclk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  // register bus model: read value is a fixed function of the address
  always @(posedge clk) begin
    if (re) begin
      rdata <= addr ^ RD_KEY;
      rd_total <= rd_total + 1;
    end
    if (we) begin
      log_addr[wr_total % 32] <= addr;
      log_data[wr_total % 32] <= wdata;
      wr_total <= wr_total + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, input int nb, output logic [15:0] rx);
    rx = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic select();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    wait_clk(3);
    // R1
    check({miso, miso_oe, we, re} == 4'b0, "R1", {miso, miso_oe, we, re}, 0);
    rst_n = 1'b1;
    wait_clk(4);
    // R2
    check({miso_oe, miso} == 2'b0, "R2", {miso_oe, miso}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] cmd, a0, n, d0;
      int wb, rb;
      bit any_miso;
      {cmd, a0, n, d0} = VEC[v];
      wb = wr_total;
      rb = rd_total;
      any_miso = 1'b0;
      select();
      xfer(cmd, 16, rx);
      xfer(a0, 16, rx);
      check(miso_oe == 1'b1, "R2", miso_oe, 1);
      for (int k = 0; k < int'(n); k++) begin
        xfer(d0 + 16'(k), 16, rx);
        if (rx != 0) any_miso = 1'b1;
        // R4 R6 R7: read word k is register a0+k
        if (cmd == 16'h0003)
          check(rx == ((a0 + 16'(k)) ^ RD_KEY), "R4/R6/R7 read", rx,
                (a0 + 16'(k)) ^ RD_KEY);
      end
      deselect();
      check({miso_oe, miso} == 2'b0, "R2", {miso_oe, miso}, 0);
      if (cmd == 16'h0002) begin
        check(wr_total - wb == int'(n), "R3/R5 write count", wr_total - wb, n);
        for (int k = 0; k < int'(n); k++) begin
          // R3 R5 R7
          check(log_addr[(wb + k) % 32] == a0 + 16'(k), "R5/R7 write addr",
                log_addr[(wb + k) % 32], a0 + 16'(k));
          check(log_data[(wb + k) % 32] == d0 + 16'(k), "R3 write data",
                log_data[(wb + k) % 32], d0 + 16'(k));
        end
      end else if (cmd == 16'h0003) begin
        check(wr_total == wb, "R6 no write", wr_total - wb, 0);
        check(rd_total - rb == int'(n) + 1, "R6 read strobes", rd_total - rb, n + 1);
      end else begin
        // R8
        check(wr_total == wb && rd_total == rb, "R8 no strobes",
              (wr_total - wb) + (rd_total - rb), 0);
        check(!any_miso, "R8 miso low", any_miso, 0);
      end
    end

    // R9: partial data word discarded
    begin
      int wb;
      wb = wr_total;
      select();
      xfer(16'h0002, 16, rx);
      xfer(16'h0033, 16, rx);
      xfer(16'hFFFF, 9, rx);
      deselect();
      check(wr_total == wb, "R9 partial word", wr_total - wb, 0);
    end

    // R10: stray bits then a clean write
    begin
      int wb;
      wb = wr_total;
      select();
      xfer(16'h001F, 5, rx);
      deselect();
      select();
      xfer(16'h0002, 16, rx);
      xfer(16'h0044, 16, rx);
      xfer(16'hCAFE, 16, rx);
      deselect();
      check(wr_total - wb == 1, "R10 write count", wr_total - wb, 1);
      check(log_addr[wb % 32] == 16'h0044, "R10 write addr", log_addr[wb % 32], 16'h0044);
      check(log_data[wb % 32] == 16'hCAFE, "R10 write data", log_data[wb % 32], 16'hCAFE);
    end

    // R11: strobes observed only while selected (sampled after deselect)
    check(!we && !re, "R11 idle strobes", {we, re}, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule